// File: doc/BRIEF.md
# Processor clock state controller

This block keeps track of which low-power clock state a processor core is in and moves between those states in response to outside events: a software halt, a stop-clock request, cache snoop requests, and sleep and deep-sleep requests. It drives an enable for the core's internal clock gate. It also drives a ready flag that drops while the core is in its deepest state and stays low through the fixed recovery time that follows.

A strap pin is sampled while reset is held. It decides what the stop-clock request does. With the strap low, the core goes to the low-latency Quick Start state. With the strap high, it goes to Stop Grant. Only one of the two can be reached between two resets. The parameter `MOBILE_ONLY` removes the states meant for desktop and server systems (Stop Grant and Sleep). With that setting, any request that would lead into them is dropped. The parameter `EXIT_CYCLES` is the Deep Sleep recovery time, counted in reference-clock cycles. Its default of 3000 is 30 µs at 100 MHz.

All pins are plain level control and status signals. No data flows through the block, so it has no valid/ready handshake. Each request is a level that the controller looks at once per clock.

Top module: `clk_state_ctrl`

## Requirements
- R1: While reset is held and afterwards, cur_state reads Normal, core_clk_en is 1 and exit_ready is 1. State codes are: Normal=0, Auto Halt=1, Quick Start=2, Stop Grant=3, Snoop=4, Sleep=5, Deep Sleep=6.
- R2: In Normal, halt_evt moves the state to Auto Halt on the next clock. A stop-clock request that can be honoured takes priority over halt_evt. In Auto Halt, wake_intr returns the state to Normal.
- R3: strap_qs_sel is captured only while rst_n is low. If it was 0, stpclk_req in Normal enters Quick Start. If it was 1, stpclk_req in Normal enters Stop Grant. Changing the strap after reset has no effect.
- R4: With MOBILE_ONLY=1, a stpclk_req made under a high strap leaves the state in Normal, and sleep_req has no effect. Stop Grant and Sleep are never entered.
- R5: snoop_req in Auto Halt, Quick Start or Stop Grant enters Snoop. snoop_done in Snoop returns to the state the snoop came from.
- R6: deep_req in Quick Start or Sleep enters Deep Sleep. exit_ready is 0 whenever the state is Deep Sleep.
- R7: After deep_req falls in Deep Sleep, the state stays in Deep Sleep for exactly EXIT_CYCLES clocks. It then returns to the state Deep Sleep was entered from. If deep_req rises again during that time, the count starts over.
- R8: core_clk_en is 1 only in Normal and Snoop.
- R9: Dropping stpclk_req returns Quick Start or Stop Grant to Normal. sleep_req in Stop Grant enters Sleep, and dropping sleep_req returns Sleep to Stop Grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset; the strap is sampled while it is low |
| strap_qs_sel | input | 1 | Reset strap: 0 selects Quick Start, 1 selects Stop Grant |
| halt_evt | input | 1 | Software halt event |
| wake_intr | input | 1 | Interrupt that ends Auto Halt |
| stpclk_req | input | 1 | Stop-clock request (level) |
| snoop_req | input | 1 | Snoop service request |
| snoop_done | input | 1 | Snoop service complete |
| sleep_req | input | 1 | Sleep request (level) |
| deep_req | input | 1 | Deep Sleep request (level) |
| cur_state | output | 3 | Current clock state code |
| core_clk_en | output | 1 | Internal clock gate enable |
| exit_ready | output | 1 | Core is available (low in Deep Sleep) |

## Verification
The bench first sweeps all 128 combinations of the seven request inputs out of Normal, under both strap values, on a mobile instance and a desktop instance side by side. This separates the priority of stop-clock over halt, the choice the strap makes, and the requests the mobile build drops. A second sweep covers every combination of stop-clock, snoop and deep requests out of Quick Start. It separates the exit path from the snoop path and the Deep Sleep entry. Directed sequences then measure the Deep Sleep exit one cycle before and at the expected edge, including a restart of the count. They also check that a snoop returns to the right state, and they run the desktop-only Stop Grant and Sleep path.

// File: rtl/clk_state_pkg.sv
package clk_state_pkg;

  typedef enum logic [2:0] {
    CS_NORMAL  = 3'd0,
    CS_AHALT   = 3'd1,
    CS_QSTART  = 3'd2,
    CS_SGRANT  = 3'd3,
    CS_SNOOP   = 3'd4,
    CS_SLEEP   = 3'd5,
    CS_DEEP    = 3'd6
  } cs_t;

  typedef struct packed {
    logic halt;
    logic intr;
    logic stp;
    logic snoop;
    logic snoop_done;
    logic sleep;
    logic deep;
  } cs_evt_t;

endpackage

// File: rtl/cs_strap_latch.sv
module cs_strap_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_in,
  output logic strap_q
);

  // Strap is loaded on every clock while reset is held, then frozen.
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_in;
  end

  assert_strap_frozen_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap_q)
  );

endmodule

// File: rtl/cs_exit_timer.sv
module cs_exit_timer #(
  parameter int EXIT_CYCLES = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_deep,
  input  logic deep_req,
  output logic done
);

  localparam int CNT_W = (EXIT_CYCLES < 2) ? 1 : $clog2(EXIT_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(EXIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             counting;

  assign counting = in_deep && !deep_req;
  assign done     = counting && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!counting) cnt_q <= '0;
    else if (!done)     cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_bound_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST
  );

  assert_cnt_restart_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    deep_req |=> cnt_q == '0
  );

endmodule

// File: rtl/cs_next_state.sv
module cs_next_state
  import clk_state_pkg::*;
#(
  parameter bit MOBILE_ONLY = 1'b1
) (
  input  cs_t     cur,
  input  cs_t     ret,
  input  logic    strap_sg,
  input  cs_evt_t ev,
  input  logic    exit_done,
  output cs_t     nxt,
  output cs_t     nxt_ret
);

  localparam bit DESK_OK = !MOBILE_ONLY;

  logic stp_ok;
  cs_t  stp_tgt;

  generate
    if (DESK_OK) begin : g_desk
      assign stp_ok  = ev.stp;
      assign stp_tgt = strap_sg ? CS_SGRANT : CS_QSTART;
    end else begin : g_mobile
      assign stp_ok  = ev.stp && !strap_sg;
      assign stp_tgt = CS_QSTART;
    end
  endgenerate

  always_comb begin
    nxt     = cur;
    nxt_ret = ret;
    unique case (cur)
      CS_NORMAL: begin
        if (stp_ok)       nxt = stp_tgt;
        else if (ev.halt) nxt = CS_AHALT;
      end
      CS_AHALT: begin
        if (ev.intr) nxt = CS_NORMAL;
        else if (ev.snoop) begin
          nxt     = CS_SNOOP;
          nxt_ret = CS_AHALT;
        end
      end
      CS_QSTART: begin
        if (!ev.stp) nxt = CS_NORMAL;
        else if (ev.snoop) begin
          nxt     = CS_SNOOP;
          nxt_ret = CS_QSTART;
        end else if (ev.deep) begin
          nxt     = CS_DEEP;
          nxt_ret = CS_QSTART;
        end
      end
      CS_SGRANT: begin
        if (!ev.stp) nxt = CS_NORMAL;
        else if (ev.snoop) begin
          nxt     = CS_SNOOP;
          nxt_ret = CS_SGRANT;
        end else if (ev.sleep && DESK_OK) nxt = CS_SLEEP;
      end
      CS_SLEEP: begin
        if (ev.deep) begin
          nxt     = CS_DEEP;
          nxt_ret = CS_SLEEP;
        end else if (!ev.sleep) nxt = CS_SGRANT;
      end
      CS_SNOOP: begin
        if (ev.snoop_done) nxt = ret;
      end
      CS_DEEP: begin
        if (exit_done) nxt = ret;
      end
      default: nxt = CS_NORMAL;
    endcase
  end

endmodule

// File: rtl/clk_state_ctrl.sv
module clk_state_ctrl
  import clk_state_pkg::*;
#(
  parameter bit MOBILE_ONLY = 1'b1,
  parameter int EXIT_CYCLES = 3000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_qs_sel,
  input  logic       halt_evt,
  input  logic       wake_intr,
  input  logic       stpclk_req,
  input  logic       snoop_req,
  input  logic       snoop_done,
  input  logic       sleep_req,
  input  logic       deep_req,
  output logic [2:0] cur_state,
  output logic       core_clk_en,
  output logic       exit_ready
);

  cs_t     state_q, ret_q, state_d, ret_d;
  cs_evt_t ev;
  logic    strap_sg;
  logic    exit_done;

  assign ev = '{halt: halt_evt, intr: wake_intr, stp: stpclk_req,
                snoop: snoop_req, snoop_done: snoop_done,
                sleep: sleep_req, deep: deep_req};

  cs_strap_latch u_strap (
    .clk      (clk),
    .rst_n    (rst_n),
    .strap_in (strap_qs_sel),
    .strap_q  (strap_sg)
  );

  cs_exit_timer #(.EXIT_CYCLES(EXIT_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_deep  (state_q == CS_DEEP),
    .deep_req (deep_req),
    .done     (exit_done)
  );

  cs_next_state #(.MOBILE_ONLY(MOBILE_ONLY)) u_next (
    .cur       (state_q),
    .ret       (ret_q),
    .strap_sg  (strap_sg),
    .ev        (ev),
    .exit_done (exit_done),
    .nxt       (state_d),
    .nxt_ret   (ret_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_NORMAL;
      ret_q   <= CS_NORMAL;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
    end
  end

  assign cur_state   = state_q;
  assign core_clk_en = (state_q == CS_NORMAL) || (state_q == CS_SNOOP);
  assign exit_ready  = (state_q != CS_DEEP);

  // ---- assertions ----
  assert_sg_needs_strap_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    (state_q == CS_SGRANT) |-> strap_sg
  );

  assert_qs_needs_strap_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    (state_q == CS_QSTART) |-> !strap_sg
  );

  assert_no_desk_states_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    MOBILE_ONLY |-> (state_q != CS_SGRANT && state_q != CS_SLEEP)
  );

  assert_snoop_return_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    (state_q == CS_SNOOP && snoop_done) |=> (cur_state == $past(ret_q))
  );

  assert_deep_exit_req_low_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    (state_q == CS_DEEP && deep_req) |=> (state_q == CS_DEEP)
  );

  assert_deep_entry_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    (state_q != CS_DEEP) |=> (state_q != CS_DEEP ||
                              $past(state_q) == CS_QSTART ||
                              $past(state_q) == CS_SLEEP)
  );

  assert_gate_off_lowpow_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    (state_q == CS_AHALT || state_q == CS_QSTART || state_q == CS_DEEP) |-> !core_clk_en
  );

  assert_stp_drop_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
    ((state_q == CS_QSTART || state_q == CS_SGRANT) && !stpclk_req) |=> (state_q == CS_NORMAL)
  );

endmodule

// File: tb/test_clk_state_ctrl.sv
module test_clk_state_ctrl;

  localparam int EXC = 5;
  localparam logic [2:0] S_N = 3'd0, S_AH = 3'd1, S_QS = 3'd2, S_SG = 3'd3,
                         S_SN = 3'd4, S_SL = 3'd5, S_DP = 3'd6;

  logic clk = 1'b0;
  logic rst_n, strap, halt, intr, stp, snp, snd, slp, dp;
  logic [2:0] st_m, st_d;
  logic gate_m, gate_d, rdy_m, rdy_d;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  clk_state_ctrl #(.MOBILE_ONLY(1'b1), .EXIT_CYCLES(EXC)) i_clk_state_ctrl (
    .clk(clk), .rst_n(rst_n), .strap_qs_sel(strap), .halt_evt(halt),
    .wake_intr(intr), .stpclk_req(stp), .snoop_req(snp), .snoop_done(snd),
    .sleep_req(slp), .deep_req(dp), .cur_state(st_m), .core_clk_en(gate_m),
    .exit_ready(rdy_m));

  clk_state_ctrl #(.MOBILE_ONLY(1'b0), .EXIT_CYCLES(EXC)) i_clk_state_ctrl_desk (
    .clk(clk), .rst_n(rst_n), .strap_qs_sel(strap), .halt_evt(halt),
    .wake_intr(intr), .stpclk_req(stp), .snoop_req(snp), .snoop_done(snd),
    .sleep_req(slp), .deep_req(dp), .cur_state(st_d), .core_clk_en(gate_d),
    .exit_ready(rdy_d));

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic clr();
    {halt, intr, stp, snp, snd, slp, dp} = '0;
  endtask

  task automatic do_reset(input logic s);
    clr();
    rst_n = 1'b0;
    strap = s;
    step(2);
    rst_n = 1'b1;
    strap = ~s;
  endtask

  function automatic logic [2:0] exp_from_normal(input logic mob, input logic s,
                                                 input logic h, input logic p);
    if (p && (!s || !mob)) return s ? S_SG : S_QS;
    if (h) return S_AH;
    return S_N;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    clr();
    rst_n = 1'b0;
    strap = 1'b0;
    step(1);
    // R1: values while reset is held
    chk("R1 state in reset", {1'b0, st_m}, {1'b0, S_N});
    chk("R1 gate/ready in reset", {2'b0, gate_m, rdy_m}, 4'b0011);
    do_reset(1'b0);
    chk("R1 state after reset", {1'b0, st_d}, {1'b0, S_N});
    chk("R8 gate in Normal", {3'b0, gate_d}, 4'd1);

    // R2/R3/R4 sweep from Normal over all seven inputs and both straps
    for (int s = 0; s < 2; s++) begin
      for (int v = 0; v < 128; v++) begin
        logic [2:0] em, ed;
        do_reset(s[0]);
        {halt, intr, stp, snp, snd, slp, dp} = v[6:0];
        step(1);
        em = exp_from_normal(1'b1, s[0], v[6], v[4]);
        ed = exp_from_normal(1'b0, s[0], v[6], v[4]);
        chk("R2 R3 R4 sweep mobile", {1'b0, st_m}, {1'b0, em});
        chk("R2 R3 sweep desktop", {1'b0, st_d}, {1'b0, ed});
        chk("R8 gate sweep", {3'b0, gate_m}, {3'b0, em == S_N});
      end
    end

    // R9/R5/R6 sweep out of Quick Start (strap 0)
    for (int v = 0; v < 8; v++) begin
      logic [2:0] e;
      do_reset(1'b0);
      stp = 1'b1;
      step(1);
      chk("R3 enter Quick Start", {1'b0, st_m}, {1'b0, S_QS});
      {stp, snp, dp} = v[2:0];
      step(1);
      e = !v[2] ? S_N : v[1] ? S_SN : v[0] ? S_DP : S_QS;
      chk("R9 R5 R6 sweep from QS", {1'b0, st_m}, {1'b0, e});
      chk("R6 ready from QS", {3'b0, rdy_d}, {3'b0, e != S_DP});
    end

    // R2: halt then interrupt; R5 snoop from Auto Halt; R8 gate
    do_reset(1'b0);
    halt = 1'b1; step(1); halt = 1'b0;
    chk("R2 enter Auto Halt", {1'b0, st_m}, {1'b0, S_AH});
    chk("R8 gate off Auto Halt", {3'b0, gate_m}, 4'd0);
    snp = 1'b1; step(1); snp = 1'b0;
    chk("R5 snoop from Auto Halt", {1'b0, st_m}, {1'b0, S_SN});
    chk("R8 gate on in Snoop", {3'b0, gate_m}, 4'd1);
    step(2);
    chk("R5 waits for done", {1'b0, st_m}, {1'b0, S_SN});
    snd = 1'b1; step(1); snd = 1'b0;
    chk("R5 return to Auto Halt", {1'b0, st_m}, {1'b0, S_AH});
    intr = 1'b1; step(1); intr = 1'b0;
    chk("R2 interrupt to Normal", {1'b0, st_m}, {1'b0, S_N});

    // R3: strap flipped after reset has no effect (strap now 1 on pin)
    stp = 1'b1; step(1);
    chk("R3 strap ignored after reset", {1'b0, st_d}, {1'b0, S_QS});
    // R6/R7: Deep Sleep from Quick Start, exit timing and restart
    dp = 1'b1; step(1);
    chk("R6 enter Deep Sleep", {1'b0, st_m}, {1'b0, S_DP});
    chk("R6 not ready in Deep", {3'b0, rdy_m}, 4'd0);
    chk("R8 gate off Deep", {3'b0, gate_m}, 4'd0);
    dp = 1'b0; step(EXC - 2);
    dp = 1'b1; step(1);
    dp = 1'b0; step(EXC - 1);
    chk("R7 held one before end", {1'b0, st_m}, {1'b0, S_DP});
    chk("R7 still not ready", {3'b0, rdy_m}, 4'd0);
    step(1);
    chk("R7 exit to Quick Start", {1'b0, st_m}, {1'b0, S_QS});
    chk("R7 ready after exit", {3'b0, rdy_m}, 4'd1);
    stp = 1'b0; step(1);
    chk("R9 stop-clock drop", {1'b0, st_m}, {1'b0, S_N});

    // R9/R4/R6/R7: desktop Stop Grant, Sleep, Deep Sleep path (strap 1)
    do_reset(1'b1);
    stp = 1'b1; slp = 1'b1; step(1);
    chk("R3 enter Stop Grant", {1'b0, st_d}, {1'b0, S_SG});
    chk("R4 mobile ignores stop-clock", {1'b0, st_m}, {1'b0, S_N});
    step(1);
    chk("R9 enter Sleep", {1'b0, st_d}, {1'b0, S_SL});
    dp = 1'b1; step(1);
    chk("R6 Deep from Sleep", {1'b0, st_d}, {1'b0, S_DP});
    dp = 1'b0; step(EXC);
    chk("R7 exit to Sleep", {1'b0, st_d}, {1'b0, S_SL});
    slp = 1'b0; step(1);
    chk("R9 Sleep back to Stop Grant", {1'b0, st_d}, {1'b0, S_SG});
    snp = 1'b1; step(1); snp = 1'b0;
    chk("R5 snoop from Stop Grant", {1'b0, st_d}, {1'b0, S_SN});
    snd = 1'b1; step(1); snd = 1'b0;
    chk("R5 return to Stop Grant", {1'b0, st_d}, {1'b0, S_SG});
    stp = 1'b0; step(1);
    chk("R9 Stop Grant to Normal", {1'b0, st_d}, {1'b0, S_N});
    chk("R4 mobile still Normal", {1'b0, st_m}, {1'b0, S_N});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule